// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends asynchronous serial frames on a single output line. Software writes a byte through a small write-only register bus into a one-entry holding register. From there the hardware moves the byte into a shift register. The shift register sends a start bit, the data least-significant bit first, an optional ninth data bit and one stop bit. Because of the holding register, the next byte can be written while the current frame is still on the line. Frames then follow each other with no idle gap.

An internal prescaler makes an oversampling tick from an 8-bit divisor. Every bit on the line lasts sixteen ticks. Two status flags are brought out as ports, each with its own interrupt request and enable:
- The holding-empty flag says a new byte may be written.
- The transmit-complete flag says the line has gone idle after the last stop bit.

The complete flag is cleared by a one-cycle acknowledge input or by a write-one to the status address. If the transmitter is switched off while it is busy, it first finishes the frame in progress and the byte still held.

Top module: `uart_tx_top`

## Requirements
- R1: After reset the line is high, the holding-empty flag is 1, the transmit-complete flag is 0, both interrupt requests are 0 and the divisor is 0.
- R2: The register map is: address 0 is data, 1 is control, 2 is divisor, 3 is status. A write to address 0 clears the holding-empty flag in the next cycle. The flag is set again when the byte moves into the shift register. Nothing else clears it.
- R3: The holding-empty interrupt request is 1 exactly while control bit 3 is 1 and the holding-empty flag is 1.
- R4: The transmit-complete flag becomes 1 only when the stop bit of a frame has ended and no byte is waiting in the holding register. At that point the line is high. The complete interrupt request is 1 exactly while control bit 4 is 1 and the flag is 1.
- R5: The transmit-complete flag is cleared by a one-cycle pulse on done_ack, or by writing a value with bit 0 set to address 3. Writing address 3 with bit 0 at 0 leaves the flag unchanged.
- R6: A frame is a start bit of 0, then eight data bits least-significant first, then one stop bit of 1. The line is 1 when no frame is being sent.
- R7: When control bit 1 is set at the time of a data write, that frame carries a ninth data bit after bit 7. Its value is control bit 2 as it stood at that data write. Later control writes do not change it.
- R8: Control bit 0 enables the transmitter. If it is cleared during a frame, that frame and any byte already held are both still sent. A byte written while the transmitter is disabled and idle stays held: the line stays high and the holding-empty flag stays 0.
- R9: When a byte is waiting as the stop bit ends, its start bit follows at once. Consecutive start bits are then exactly 160·(divisor+1) clock cycles apart.
- R10: When the transmitter is enabled and idle, a data write starts the frame at the next tick. The start bit appears between 1 and divisor+1 cycles after the write.
- R11: Each bit lasts 16·(divisor+1) clock cycles. This includes divisor 0, which gives 16 cycles per bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 data, 1 control, 2 divisor, 3 status) |
| bus_wdata | input | 8 | Write data |
| done_ack | input | 1 | Acknowledge pulse for the transmit-complete interrupt |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Holding-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
The assertions assume the following about the inputs:
- The bus carries at most one write per cycle.
- bus_addr is valid whenever bus_wr is high.
- done_ack is a single-cycle pulse.

The stimulus drives every input on the falling clock edge and holds it for a full cycle. It changes the divisor only while the line is idle, and it raises done_ack only between frames. A behavioural reference model built from the requirements is compared with all five outputs in every cycle. Sampled frames are also decoded at bit centres to check data, ninth bit, spacing and start latency.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIV  = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;

    // packed: first member is the most significant bit (bit 4 .. bit 0)
    typedef struct packed {
        logic done_ie;   // bit 4
        logic empty_ie;  // bit 3
        logic bit8;      // bit 2
        logic nine;      // bit 1
        logic en;        // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // a tick every (div+1) clocks; >= keeps it sane if div shrinks
    assign tick = (cnt_q >= div);

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_nine,
    input  logic              hold_b8,
    output logic              txd,
    output logic              take,
    output logic              finish
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int SUB_W   = $clog2(OVS);
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_NINE = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] LAST_EIGHT = IDX_W'(FRAME_W - 2);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [SUB_W-1:0]   sub;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
    } sh_t;

    sh_t s_d, s_q;
    logic load;

    always_comb begin
        s_d    = s_q;
        load   = 1'b0;
        finish = 1'b0;
        if (tick) begin
            if (!s_q.busy) begin
                load = hold_valid && tx_en;
            end else if (s_q.sub == SUB_LAST) begin
                if (s_q.idx == s_q.last) begin
                    // frame ends: a held byte goes out even if disabled
                    if (hold_valid) load = 1'b1;
                    else begin
                        s_d.busy = 1'b0;
                        finish   = 1'b1;
                    end
                end else begin
                    s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.sub   = '0;
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
        if (load) begin
            s_d.busy  = 1'b1;
            s_d.sub   = '0;
            s_d.idx   = '0;
            s_d.frame = {1'b1, (hold_nine ? hold_b8 : 1'b1), hold_data, 1'b0};
            s_d.last  = hold_nine ? LAST_NINE : LAST_EIGHT;
        end
        take = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign txd = s_q.busy ? s_q.frame[0] : 1'b1;
endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              done_ack,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] hold_data;
        logic              hold_nine;
        logic              hold_b8;
        logic              hold_full;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, take, finish;

    uart_tx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (r_q.div),
        .tick (tick)
    );

    uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_valid(r_q.hold_full),
        .tx_en     (r_q.ctrl.en),
        .hold_data (r_q.hold_data),
        .hold_nine (r_q.hold_nine),
        .hold_b8   (r_q.hold_b8),
        .txd       (txd),
        .take      (take),
        .finish    (finish)
    );

    always_comb begin
        r_d = r_q;
        if (take) r_d.hold_full = 1'b0;
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                REG_DATA: begin
                    r_d.hold_data = bus_wdata;
                    r_d.hold_nine = r_q.ctrl.nine;
                    r_d.hold_b8   = r_q.ctrl.bit8;
                    r_d.hold_full = 1'b1;
                end
                REG_CTRL: r_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                REG_DIV:  r_d.div  = bus_wdata[DIV_W-1:0];
                REG_STAT: if (bus_wdata[0]) r_d.done = 1'b0;
                default:  ;
            endcase
        end
        if (done_ack) r_d.done = 1'b0;
        if (finish)   r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_empty = !r_q.hold_full;
    assign tx_done    = r_q.done;
    assign irq_empty  = r_q.ctrl.empty_ie && !r_q.hold_full;
    assign irq_done   = r_q.ctrl.done_ie && r_q.done;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_done,
    input logic       irq_empty,
    input logic       irq_done
);
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> !hold_empty);

    p_fill_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(bus_wr && bus_addr == 2'd0));

    p_irq_empty_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> hold_empty);

    p_irq_done_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> tx_done);

    p_done_line_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> txd);

    p_done_nothing_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(hold_empty));
endmodule

bind uart_tx_top uart_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .txd       (txd),
    .hold_empty(hold_empty),
    .tx_done   (tx_done),
    .irq_empty (irq_empty),
    .irq_done  (irq_done)
);

// File: tb/uart_tx_top_bench.sv
module uart_tx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       done_ack = 1'b0;
    logic       txd, hold_empty, tx_done, irq_empty, irq_done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int cur_div = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    uart_tx_top u_uart_tx_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .done_ack(done_ack), .txd(txd),
        .hold_empty(hold_empty), .tx_done(tx_done),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pcnt, m_div, m_sub, m_idx, m_hdata;
    bit m_en, m_nine, m_b8, m_iee, m_ied;
    bit m_hfull, m_hnine, m_hb8, m_busy, m_done;
    bit m_bits[$];

    task automatic m_load();
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_bits.push_back(m_hdata[i]);
        if (m_hnine) m_bits.push_back(m_hb8);
        m_bits.push_back(1'b1);
        m_busy = 1; m_sub = 0; m_idx = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        bit tk, took, fin;
        if (!rst_n) begin
            m_pcnt = 0; m_div = 0; m_sub = 0; m_idx = 0; m_hdata = 0;
            m_en = 0; m_nine = 0; m_b8 = 0; m_iee = 0; m_ied = 0;
            m_hfull = 0; m_hnine = 0; m_hb8 = 0; m_busy = 0; m_done = 0;
            m_bits.delete();
        end else begin
            took = 0; fin = 0;
            tk = (m_pcnt >= m_div);
            m_pcnt = tk ? 0 : m_pcnt + 1;
            if (tk) begin
                if (!m_busy) begin
                    if (m_hfull && m_en) begin m_load(); took = 1; end
                end else if (m_sub == 15) begin
                    if (m_idx == m_bits.size() - 1) begin
                        if (m_hfull) begin m_load(); took = 1; end
                        else begin m_busy = 0; fin = 1; end
                    end else begin
                        m_idx++; m_sub = 0;
                    end
                end else m_sub++;
            end
            if (took) m_hfull = 0;
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: begin m_hdata = bus_wdata; m_hnine = m_nine; m_hb8 = m_b8; m_hfull = 1; end
                    2'd1: begin m_en = bus_wdata[0]; m_nine = bus_wdata[1]; m_b8 = bus_wdata[2];
                                m_iee = bus_wdata[3]; m_ied = bus_wdata[4]; end
                    2'd2: m_div = bus_wdata;
                    default: if (bus_wdata[0]) m_done = 0;
                endcase
            end
            if (done_ack) m_done = 0;
            if (fin) m_done = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R6 txd vs model", txd, m_busy ? m_bits[m_idx] : 1);
            chk("R2 hold_empty vs model", hold_empty, !m_hfull);
            chk("R4 tx_done vs model", tx_done, m_done);
            chk("R3 irq_empty vs model", irq_empty, m_iee && !m_hfull);
            chk("R4 irq_done vs model", irq_done, m_ied && m_done);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd2) cur_div = d;
    endtask

    task automatic ack_pulse();
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
    endtask

    task automatic rx_frame(input bit nine, output int data, output int b8,
                            output int stopb, output int start_cyc);
        int t;
        t = 16 * (cur_div + 1);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) break;
        end
        start_cyc = cyc;
        repeat (t / 2) @(negedge clk);
        data = 0; b8 = 0;
        for (int i = 0; i < 8; i++) begin
            repeat (t) @(negedge clk);
            data[i] = txd;
        end
        if (nine) begin
            repeat (t) @(negedge clk);
            b8 = txd;
        end
        repeat (t) @(negedge clk);
        stopb = txd;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int d, b, s, st, st2, wc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 txd idle", txd, 1);
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 tx_done", tx_done, 0);
        chk("R1 irq_empty", irq_empty, 0);
        chk("R1 irq_done", irq_done, 0);

        bus_write(2'd2, 8'd3);
        bus_write(2'd1, 8'h19);          // en, empty_ie, done_ie
        chk("R3 irq_empty enabled", irq_empty, 1);

        // single frame, start latency
        bus_write(2'd0, 8'hA5);
        wc = cyc;
        rx_frame(0, d, b, s, st);
        chk("R6 data", d, 8'hA5);
        chk("R6 stop bit", s, 1);
        chk("R10 start latency in range", (st - wc >= 1) && (st - wc <= cur_div + 1), 1);
        repeat (80) @(negedge clk);
        chk("R4 done after frame", tx_done, 1);
        chk("R4 irq_done", irq_done, 1);

        // R5 write-one-to-clear
        bus_write(2'd3, 8'h00);
        chk("R5 write zero keeps flag", tx_done, 1);
        bus_write(2'd3, 8'h01);
        chk("R5 write one clears flag", tx_done, 0);

        // R9 back-to-back
        fork
            begin
                rx_frame(0, d, b, s, st);
                chk("R9 first data", d, 8'h3C);
                chk("R4 no done between frames", tx_done, 0);
                rx_frame(0, d, b, s, st2);
                chk("R9 second data", d, 8'hC3);
                chk("R9 spacing", st2 - st, 160 * (cur_div + 1));
            end
            begin
                bus_write(2'd0, 8'h3C);
                while (hold_empty !== 1'b1) @(negedge clk);
                bus_write(2'd0, 8'hC3);
            end
        join
        repeat (80) @(negedge clk);
        chk("R4 done after pair", tx_done, 1);
        ack_pulse();
        chk("R5 ack clears flag", tx_done, 0);

        // R7 nine-bit mode, bit sampled at data write
        bus_write(2'd1, 8'h1F);
        bus_write(2'd0, 8'h5A);
        bus_write(2'd1, 8'h1B);          // bit8 now 0, held byte keeps 1
        rx_frame(1, d, b, s, st);
        chk("R7 data", d, 8'h5A);
        chk("R7 ninth bit", b, 1);
        chk("R7 stop", s, 1);
        bus_write(2'd0, 8'h81);
        rx_frame(1, d, b, s, st);
        chk("R7 data 2", d, 8'h81);
        chk("R7 ninth bit 0", b, 0);
        repeat (80) @(negedge clk);

        // R8 deferred disable
        bus_write(2'd1, 8'h19);
        fork
            begin
                rx_frame(0, d, b, s, st);
                chk("R8 first after disable", d, 8'h11);
                rx_frame(0, d, b, s, st);
                chk("R8 held byte still sent", d, 8'h22);
            end
            begin
                bus_write(2'd0, 8'h11);
                while (hold_empty !== 1'b1) @(negedge clk);
                bus_write(2'd0, 8'h22);
                bus_write(2'd1, 8'h18);
            end
        join
        repeat (80) @(negedge clk);
        bus_write(2'd0, 8'h33);
        repeat (300) @(negedge clk);
        chk("R8 disabled byte held", hold_empty, 0);
        chk("R8 line idle while disabled", txd, 1);
        bus_write(2'd1, 8'h19);
        rx_frame(0, d, b, s, st);
        chk("R8 byte sent on re-enable", d, 8'h33);
        repeat (80) @(negedge clk);

        // R11 divisor 0
        bus_write(2'd2, 8'd0);
        bus_write(2'd0, 8'h96);
        wc = cyc;
        rx_frame(0, d, b, s, st);
        chk("R11 data at divisor 0", d, 8'h96);
        chk("R11 start latency", st - wc, 1);
        repeat (40) @(negedge clk);

        // R3 enable gating
        bus_write(2'd1, 8'h01);
        chk("R3 irq_empty masked", irq_empty, 0);
        chk("R3 flag still set", hold_empty, 1);

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule